// File: doc/BRIEF.md
# Endpoint-Zero Control/Status Register

This block keeps the eight-bit control and status word for the default control endpoint of a USB device controller. The processor side reads the word combinationally and writes it one byte at a time with a strobe. The USB protocol engine drives single-cycle event pulses into the block: a control transfer ended early, a valid OUT packet landed in the FIFO, a queued IN packet reached the host, the transaction was stopped for a protocol error, and the status stage finished (which clears data-end).

Each bit follows its own ownership rule. Some bits are raised by the USB side and can only be cleared through write-one service bits. Some are raised by the processor and dropped by the USB side. One bit is cleared by writing zero. When the two sides act on the same bit in the same cycle, the block settles it so that a set is never lost. The block also issues a one-cycle interrupt pulse and keeps a sticky pending flag behind it. An early end of the transfer requests a FIFO flush and marks processor FIFO access as invalid until software services it.

Top module: `ep0_ctl_stat_reg`

## Requirements
- R1: After reset the register reads 0x00, and irq_pulse, irq_pending, fifo_flush, fifo_access_bad and stall_handshake are all low.
- R2: Bits 7 and 6 always read 0. Writing 1 to bit 7 clears setup-end (bit 4). Writing 1 to bit 6 clears out-ready (bit 0).
- R3: ev_setup_end sets bit 4 one cycle later. It gives a fifo_flush pulse exactly one cycle long in that same cycle. fifo_access_bad then stays high until bit 4 is cleared.
- R4: ev_out_ready sets bit 0. Writes to bits 4 and 0 never set them.
- R5: Writing 1 to bit 1 sets in-ready. Writing 0 to bit 1 leaves it unchanged. ev_in_sent clears it.
- R6: Writing 1 to bit 3 sets data-end. Writing 0 to bit 3 leaves it unchanged. ev_data_end_clr clears it.
- R7: Bit 5 (send-stall) takes the written value on every write, and stall_handshake follows it.
- R8: ev_stall_sent sets bit 2. A write with bit 2 at 0 clears it. A write with bit 2 at 1 leaves it unchanged.
- R9: When a set and a clear of the same bit happen in the same cycle, the bit ends up set.
- R10: irq_pulse is high for the one cycle after ev_setup_end, ev_out_ready or ev_stall_sent. It is also high after ev_in_sent, but only while in-ready was set; ev_in_sent with in-ready clear raises no pulse.
- R11: irq_pending goes high the cycle after irq_pulse and stays high until irq_ack. A pulse that arrives together with irq_ack keeps it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Processor write strobe |
| wr_data | input | REG_W | Processor write byte |
| rd_data | output | REG_W | Register read value |
| ev_setup_end | input | 1 | Control transfer ended before data-end |
| ev_out_ready | input | 1 | Valid OUT packet written to FIFO |
| ev_in_sent | input | 1 | IN packet delivered to host |
| ev_stall_sent | input | 1 | Transaction stopped by protocol violation |
| ev_data_end_clr | input | 1 | USB side clears data-end |
| irq_ack | input | 1 | Clears the pending interrupt flag |
| irq_pulse | output | 1 | One-cycle endpoint interrupt request |
| irq_pending | output | 1 | Sticky interrupt flag |
| fifo_flush | output | 1 | One-cycle FIFO flush request |
| fifo_access_bad | output | 1 | Processor FIFO access invalid |
| stall_handshake | output | 1 | Answer current transfer with STALL |

## Verification
A flag cell that takes the wrong value shows up on rd_data at the first sample after the clock edge that updated it. This is one cycle after the event or write, because every flag is a single register. A broken priority between set and clear shows as a dropped bit in that same cycle. A wrong interrupt qualifier shows on irq_pulse one cycle after the event, and on irq_pending one cycle after that. A flush or access-invalid fault shows on fifo_flush and fifo_access_bad while the setup-end bit is set, so the bench samples those outputs over several cycles of that window.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;
   // bit positions software decodes
   localparam int BIT_OUT_RDY   = 0;
   localparam int BIT_IN_RDY    = 1;
   localparam int BIT_SENT_STL  = 2;
   localparam int BIT_DATA_END  = 3;
   localparam int BIT_SETUP_END = 4;
   localparam int BIT_SEND_STL  = 5;
   localparam int BIT_SVC_OUT   = 6;
   localparam int BIT_SVC_SETUP = 7;
   localparam int NUM_FLAGS     = 6;

   typedef struct packed {
      logic setup_end;
      logic out_ready;
      logic in_sent;
      logic stall_sent;
      logic data_end_clr;
   } usb_ev_t;
endpackage

// File: rtl/ep0_flag_bit.sv
module ep0_flag_bit #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_r;

   generate
      if (SET_WINS) begin : g_set_pri
         always_ff @(posedge clk) begin
            if (!rst_n)     q_r <= 1'b0;
            else if (set_i) q_r <= 1'b1;
            else if (clr_i) q_r <= 1'b0;
         end
      end else begin : g_clr_pri
         always_ff @(posedge clk) begin
            if (!rst_n)     q_r <= 1'b0;
            else if (clr_i) q_r <= 1'b0;
            else if (set_i) q_r <= 1'b1;
         end
      end
   endgenerate

   assign q_o = q_r;
endmodule

// File: rtl/ep0_flag_ctrl.sv
module ep0_flag_ctrl
   import ep0_csr_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic                 wr_en,
   input  logic [REG_W-1:0]     wr_data,
   input  usb_ev_t              ev,
   output logic [NUM_FLAGS-1:0] set_o,
   output logic [NUM_FLAGS-1:0] clr_o
);
   always_comb begin
      set_o = '0;
      clr_o = '0;
      set_o[BIT_OUT_RDY]   = ev.out_ready;
      clr_o[BIT_OUT_RDY]   = wr_en & wr_data[BIT_SVC_OUT];
      set_o[BIT_IN_RDY]    = wr_en & wr_data[BIT_IN_RDY];
      clr_o[BIT_IN_RDY]    = ev.in_sent;
      set_o[BIT_SENT_STL]  = ev.stall_sent;
      clr_o[BIT_SENT_STL]  = wr_en & ~wr_data[BIT_SENT_STL];
      set_o[BIT_DATA_END]  = wr_en & wr_data[BIT_DATA_END];
      clr_o[BIT_DATA_END]  = ev.data_end_clr;
      set_o[BIT_SETUP_END] = ev.setup_end;
      clr_o[BIT_SETUP_END] = wr_en & wr_data[BIT_SVC_SETUP];
      set_o[BIT_SEND_STL]  = wr_en & wr_data[BIT_SEND_STL];
      clr_o[BIT_SEND_STL]  = wr_en & ~wr_data[BIT_SEND_STL];
   end
endmodule

// File: rtl/ep0_irq_gen.sv
module ep0_irq_gen
   import ep0_csr_pkg::*;
#(
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  usb_ev_t ev,
   input  logic    in_rdy_q,
   input  logic    irq_ack,
   output logic    irq_pulse,
   output logic    irq_pending,
   output logic    fifo_flush
);
   logic irq_raw;
   logic pend_r;
   logic flush_r;

   assign irq_raw = ev.setup_end | ev.out_ready | ev.stall_sent
                  | (ev.in_sent & in_rdy_q);

   generate
      if (IRQ_REGISTERED) begin : g_reg_irq
         logic pulse_r;
         always_ff @(posedge clk) begin
            if (!rst_n) pulse_r <= 1'b0;
            else        pulse_r <= irq_raw;
         end
         assign irq_pulse = pulse_r;
      end else begin : g_comb_irq
         assign irq_pulse = irq_raw;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_r  <= 1'b0;
         flush_r <= 1'b0;
      end else begin
         flush_r <= ev.setup_end;
         if (irq_pulse)    pend_r <= 1'b1;
         else if (irq_ack) pend_r <= 1'b0;
      end
   end

   assign irq_pending = pend_r;
   assign fifo_flush  = flush_r;
endmodule

// File: rtl/ep0_ctl_stat_reg.sv
module ep0_ctl_stat_reg
   import ep0_csr_pkg::*;
#(
   parameter int REG_W          = 8,
   parameter bit SET_WINS       = 1'b1,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             ev_setup_end,
   input  logic             ev_out_ready,
   input  logic             ev_in_sent,
   input  logic             ev_stall_sent,
   input  logic             ev_data_end_clr,
   input  logic             irq_ack,
   output logic             irq_pulse,
   output logic             irq_pending,
   output logic             fifo_flush,
   output logic             fifo_access_bad,
   output logic             stall_handshake
);
   localparam int PAD_W = REG_W - NUM_FLAGS;

   generate
      if (REG_W < 8) begin : g_bad_width
         $error("ep0_ctl_stat_reg: REG_W must be at least 8");
      end
   endgenerate

   usb_ev_t              ev;
   logic [NUM_FLAGS-1:0] set_v;
   logic [NUM_FLAGS-1:0] clr_v;
   logic [NUM_FLAGS-1:0] flags_q;

   assign ev = '{setup_end:    ev_setup_end,
                 out_ready:    ev_out_ready,
                 in_sent:      ev_in_sent,
                 stall_sent:   ev_stall_sent,
                 data_end_clr: ev_data_end_clr};

   ep0_flag_ctrl #(.REG_W(REG_W)) ctrl_i (
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .ev      (ev),
      .set_o   (set_v),
      .clr_o   (clr_v)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
         ep0_flag_bit #(.SET_WINS(SET_WINS)) bit_i (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[gi]),
            .clr_i (clr_v[gi]),
            .q_o   (flags_q[gi])
         );
      end
   endgenerate

   ep0_irq_gen #(.IRQ_REGISTERED(IRQ_REGISTERED)) irq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev          (ev),
      .in_rdy_q    (flags_q[BIT_IN_RDY]),
      .irq_ack     (irq_ack),
      .irq_pulse   (irq_pulse),
      .irq_pending (irq_pending),
      .fifo_flush  (fifo_flush)
   );

   assign rd_data         = {{PAD_W{1'b0}}, flags_q};
   assign fifo_access_bad = flags_q[BIT_SETUP_END];
   assign stall_handshake = flags_q[BIT_SEND_STL];
endmodule

// File: rtl/ep0_ctl_stat_chk.sv
module ep0_ctl_stat_chk #(
   parameter int REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic [REG_W-1:0] rd_data,
   input logic             ev_setup_end,
   input logic             ev_out_ready,
   input logic             ev_stall_sent,
   input logic             irq_ack,
   input logic             irq_pulse,
   input logic             irq_pending,
   input logic             fifo_flush,
   input logic             fifo_access_bad
);
   AST_SVC_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[7:6] == 2'b00); // R2
   AST_SVC_SETUP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[7] && !ev_setup_end) |=> !rd_data[4]); // R2
   AST_FLUSH_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_flush |-> $past(ev_setup_end)); // R3
   AST_BAD_ROSE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_access_bad) |-> fifo_flush); // R3
   AST_STALL_WR0_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[2] && !ev_stall_sent) |=> !rd_data[2]); // R8
   AST_OUT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_out_ready |=> rd_data[0]); // R9
   AST_PULSE_TO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> irq_pending); // R11
   AST_PEND_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !irq_pulse) |=> !irq_pending); // R11
endmodule

bind ep0_ctl_stat_reg ep0_ctl_stat_chk #(.REG_W(REG_W)) chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .wr_en           (wr_en),
   .wr_data         (wr_data),
   .rd_data         (rd_data),
   .ev_setup_end    (ev_setup_end),
   .ev_out_ready    (ev_out_ready),
   .ev_stall_sent   (ev_stall_sent),
   .irq_ack         (irq_ack),
   .irq_pulse       (irq_pulse),
   .irq_pending     (irq_pending),
   .fifo_flush      (fifo_flush),
   .fifo_access_bad (fifo_access_bad)
);

// File: tb/ep0_ctl_stat_reg_tb_top.sv
module ep0_ctl_stat_reg_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       ev_setup_end = 0, ev_out_ready = 0, ev_in_sent = 0;
   logic       ev_stall_sent = 0, ev_data_end_clr = 0, irq_ack = 0;
   logic       irq_pulse, irq_pending, fifo_flush, fifo_access_bad, stall_handshake;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   ep0_ctl_stat_reg dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .ev_setup_end(ev_setup_end), .ev_out_ready(ev_out_ready), .ev_in_sent(ev_in_sent),
      .ev_stall_sent(ev_stall_sent), .ev_data_end_clr(ev_data_end_clr), .irq_ack(irq_ack),
      .irq_pulse(irq_pulse), .irq_pending(irq_pending), .fifo_flush(fifo_flush),
      .fifo_access_bad(fifo_access_bad), .stall_handshake(stall_handshake)
   );

   // {wr, wdata, ev(setup,out,insent,stall,declr), exp_rd, exp_irq, exp_flush}
   localparam int NV = 15;
   localparam logic [23:0] VEC [NV] = '{
      {1'b0, 8'h00, 5'b00000, 8'h00, 1'b0, 1'b0},   // idle
      {1'b0, 8'h00, 5'b01000, 8'h01, 1'b1, 1'b0},   // R4 out ready
      {1'b1, 8'h02, 5'b00000, 8'h03, 1'b0, 1'b0},   // R5 load IN
      {1'b0, 8'h00, 5'b00100, 8'h01, 1'b1, 1'b0},   // R5 R10 IN sent
      {1'b1, 8'h68, 5'b00000, 8'h28, 1'b0, 1'b0},   // R2 R6 R7 svc+stall+end
      {1'b0, 8'h00, 5'b00010, 8'h2C, 1'b1, 1'b0},   // R8 stall sent
      {1'b1, 8'h24, 5'b00000, 8'h2C, 1'b0, 1'b0},   // R8 write 1 keeps
      {1'b1, 8'h00, 5'b00000, 8'h08, 1'b0, 1'b0},   // R6 R7 R8 write 0
      {1'b0, 8'h00, 5'b00001, 8'h00, 1'b0, 1'b0},   // R6 USB clears
      {1'b0, 8'h00, 5'b10000, 8'h10, 1'b1, 1'b1},   // R3 setup end
      {1'b1, 8'h11, 5'b00000, 8'h10, 1'b0, 1'b0},   // R4 RO bits
      {1'b1, 8'h80, 5'b00000, 8'h00, 1'b0, 1'b0},   // R2 svc setup
      {1'b1, 8'h40, 5'b01000, 8'h01, 1'b1, 1'b0},   // R9 out set wins
      {1'b1, 8'hC4, 5'b10000, 8'h10, 1'b1, 1'b1},   // R9 setup set wins
      {1'b1, 8'h80, 5'b00000, 8'h00, 1'b0, 1'b0}    // R2
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clr_in();
      wr_en = 0; wr_data = '0; ev_setup_end = 0; ev_out_ready = 0;
      ev_in_sent = 0; ev_stall_sent = 0; ev_data_end_clr = 0; irq_ack = 0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (10000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 rd", rd_data, 8'h00);
      chk("R1 outs", {3'b0, irq_pulse, irq_pending, fifo_flush, fifo_access_bad, stall_handshake}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rd after release", rd_data, 8'h00);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         wr_en = VEC[i][23]; wr_data = VEC[i][22:15];
         {ev_setup_end, ev_out_ready, ev_in_sent, ev_stall_sent, ev_data_end_clr} = VEC[i][14:10];
         @(negedge clk);
         clr_in();
         chk($sformatf("vec%0d rd", i), rd_data, VEC[i][9:2]);
         chk($sformatf("vec%0d R10 irq", i), {7'b0, irq_pulse}, {7'b0, VEC[i][1]});
         chk($sformatf("vec%0d R3 flush", i), {7'b0, fifo_flush}, {7'b0, VEC[i][0]});
      end

      // R11 sticky then ack
      @(negedge clk);
      chk("R11 pending held", {7'b0, irq_pending}, 8'h01);
      irq_ack = 1;
      @(negedge clk);
      clr_in();
      chk("R11 ack clears", {7'b0, irq_pending}, 8'h00);

      // R10 in_sent without in-ready: no pulse
      ev_in_sent = 1;
      @(negedge clk);
      clr_in();
      chk("R10 no irq idle in", {7'b0, irq_pulse}, 8'h00);
      chk("R5 in stays clear", rd_data, 8'h00);

      // R3 flush one cycle, access-bad held
      ev_setup_end = 1;
      @(negedge clk);
      clr_in();
      chk("R3 flush on", {7'b0, fifo_flush}, 8'h01);
      irq_ack = 1; // R11 ack together with pulse: pending must still set
      @(negedge clk);
      clr_in();
      chk("R3 flush off", {7'b0, fifo_flush}, 8'h00);
      chk("R11 pulse beats ack", {7'b0, irq_pending}, 8'h01);
      repeat (3) @(negedge clk);
      chk("R3 bad held", {7'b0, fifo_access_bad}, 8'h01);
      wr_en = 1; wr_data = 8'h80;
      @(negedge clk);
      clr_in();
      chk("R3 bad released", {7'b0, fifo_access_bad}, 8'h00);

      // R7 stall handshake output
      wr_en = 1; wr_data = 8'h24;
      @(negedge clk);
      clr_in();
      chk("R7 stall on", {7'b0, stall_handshake}, 8'h01);
      wr_en = 1; wr_data = 8'h04;
      @(negedge clk);
      clr_in();
      chk("R7 stall off", {7'b0, stall_handshake}, 8'h00);

      // R9 data-end set beats USB clear; R6 then cleared
      wr_en = 1; wr_data = 8'h0C; ev_data_end_clr = 1;
      @(negedge clk);
      clr_in();
      chk("R9 data-end set wins", rd_data, 8'h08);
      ev_data_end_clr = 1;
      @(negedge clk);
      clr_in();
      chk("R6 data-end cleared", rd_data, 8'h00);

      done = 1'b1;
      finish_run();
   end
endmodule